// File: doc/BRIEF.md
# Queue Head Overlay Traversal Controller

This controller walks a singly linked chain of queue heads held in word-addressed memory. At each queue head it loads the horizontal link, the current-descriptor pointer and a nine-word transfer overlay into local registers, then looks at the active flag in the overlay status word. An idle overlay sends the walk straight on to the next queue head.

An active overlay starts a stub transfer. The transfer lowers a bytes-remaining count in fixed steps and writes every new status back into the queue head's overlay. When the count reaches zero it clears the active flag. The controller then copies all nine overlay words to the descriptor that the current-descriptor pointer names. The walk ends after a queue head whose link carries the terminate flag.

Software starts a walk with a one-cycle `start` and the word address of the first queue head. It watches `busy`, and `done` pulses once at the end. The memory port uses a request/ready handshake. Read data returns with a valid strobe one cycle after a read is accepted.

Top module: `qh_walker`

## Requirements
- R1: Out of reset, `busy`, `done` and `mem_req` are all low.
- R2: A `start` in idle begins a walk at word address `first_qh`. `busy` stays high until the walk ends. `done` is then high for exactly one cycle, with `busy` already low.
- R3: For each queue head the controller reads word offset 0 (horizontal link), offset 3 (current-descriptor pointer) and offsets 4 to 12 (the nine overlay words). That is 11 reads per queue head. A word is taken only on the cycle `mem_rvalid` is high, one cycle after the read was accepted.
- R4: The overlay status word is overlay word 2, at queue head offset 6, and bit 7 is its active flag. When bit 7 is clear, the controller makes no write at that queue head. It moves on to word address `{link[AW+1:5],3'b000}`.
- R5: When bit 0 of the horizontal link is set, the walk ends after that queue head has been handled.
- R6: While active, each step lowers status bits 30:16 by `CHUNK`, stopping at zero, and writes the new status to queue head offset 6. Every other status bit is kept. The write that brings the count to zero also clears bit 7. A count that starts at zero takes exactly one step.
- R7: After the final step, the nine overlay words go to word addresses D+0 through D+8, where D = `{cur[AW+1:5],3'b000}`. Bits 4:0 of the pointer are ignored. The word at D+9 is left untouched.
- R8: The overlay next-descriptor and alternate-descriptor pointers (overlay words 0 and 1) are never used as memory addresses.
- R9: A request holds its address, direction and data until `mem_ready` is high. Stalls delay the walk but do not change any result.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (idle only) |
| first_qh | input | AW | Word address of first queue head |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The delicate overlap is the final status step, where the active-clearing write and the entry into write-back meet. If `mem_ready` drops on that cycle, the controller must neither repeat the step nor skip the first descriptor word. This overlap is provoked by running a chain of mixed active and idle queue heads under pseudo-random ready stalls. It is judged by exact write counts, the final status in each queue head and every descriptor word, plus the word just past each descriptor. A second overlap, a `start` arriving while a walk is still running, is driven in its own test. It is judged by confirming that the other descriptor keeps its sentinel.

// File: rtl/qh_walker.sv
module qh_walker #(
  parameter int AW    = 12,
  parameter int CHUNK = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_qh,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid
);

  localparam int         OVW      = 9;
  localparam logic [3:0] OFF_CUR  = 4'd3;
  localparam logic [3:0] OFF_OV   = 4'd4;
  localparam logic [3:0] OFF_STAT = 4'd6;
  localparam logic [3:0] OFF_LAST = OFF_OV + 4'(OVW - 1);
  localparam logic [3:0] WB_LAST  = 4'(OVW - 1);
  localparam logic [14:0] STEP    = 15'(CHUNK);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_XFER, S_WB, S_NEXT} st_t;

  st_t           state;
  logic [AW-1:0] qh;
  logic [31:0]   link, cur;
  logic [31:0]   ov [OVW];
  logic [3:0]    idx, k;

  logic [14:0]   rem, stepped;
  logic [31:0]   new_status;
  logic [AW-1:0] desc_base, next_qh;
  logic          accept;

  assign rem        = ov[2][30:16];
  assign stepped    = (rem > STEP) ? rem - STEP : '0;
  assign new_status = {ov[2][31], stepped, ov[2][15:8], (stepped != '0) & ov[2][7], ov[2][6:0]};
  assign desc_base  = {cur[AW+1:5], 3'b000};
  assign next_qh    = {link[AW+1:5], 3'b000};

  assign busy    = (state != S_IDLE);
  assign mem_req = (state == S_RD) || (state == S_XFER) || (state == S_WB);
  assign mem_we  = (state == S_XFER) || (state == S_WB);
  assign accept  = mem_req && mem_ready;

  always_comb begin
    case (state)
      S_XFER:  mem_addr = qh + AW'(OFF_STAT);
      S_WB:    mem_addr = desc_base + AW'(k);
      default: mem_addr = qh + AW'(idx);
    endcase
    case (state)
      S_XFER:  mem_wdata = new_status;
      S_WB:    mem_wdata = ov[k];
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      qh    <= '0;
      link  <= '0;
      cur   <= '0;
      idx   <= '0;
      k     <= '0;
      done  <= 1'b0;
      for (int i = 0; i < OVW; i++) ov[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (start) begin
            qh    <= first_qh;
            idx   <= '0;
            state <= S_RD;
          end
        S_RD:
          if (accept) state <= S_RWAIT;
        S_RWAIT:
          if (mem_rvalid) begin
            if (idx == '0)           link <= mem_rdata;
            else if (idx == OFF_CUR) cur  <= mem_rdata;
            else                     ov[idx - OFF_OV] <= mem_rdata;
            if (idx == OFF_LAST) begin
              state <= (ov[2][7] && idx != OFF_STAT) ? S_XFER : S_NEXT;
            end else begin
              idx   <= (idx == '0) ? OFF_CUR : idx + 4'd1;
              state <= S_RD;
            end
          end
        S_XFER:
          if (accept) begin
            ov[2] <= new_status;
            if (stepped == '0) begin
              k     <= '0;
              state <= S_WB;
            end
          end
        S_WB:
          if (accept) begin
            if (k == WB_LAST) state <= S_NEXT;
            else              k     <= k + 4'd1;
          end
        S_NEXT:
          if (link[0]) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            qh    <= next_qh;
            idx   <= '0;
            state <= S_RD;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R3
  rvalid_wait_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rvalid |-> state == S_RWAIT);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  wb_consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && $past(state == S_WB && mem_ready)) |-> mem_addr == AW'($past(mem_addr) + 1'b1));

  // R6
  wb_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_WB) |-> !ov[2][7]);

  // R4
  idle_ov_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NEXT && $past(state == S_RWAIT)) |-> !ov[2][7]);

endmodule

// File: tb/qh_walker_test.sv
`timescale 1ns/1ps
module qh_walker_test;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] first_qh = '0;
  logic busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ready = 1, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [1 << AW];
  logic ld_en = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic stall = 0;
  logic [7:0] lfsr = 8'h5a;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, bad_done = 0, fwd_hits = 0;
  int checks = 0, errors = 0;

  qh_walker #(.AW(AW), .CHUNK(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_qh(first_qh),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (ld_en) mem[ld_addr] <= ld_data;
    if (mem_req && mem_ready) begin
      if (mem_addr >= 12'h300 && mem_addr <= 12'h30f) fwd_hits <= fwd_hits + 1;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata  <= mem[mem_addr];
        mem_rvalid <= 1'b1;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (done) done_cnt <= done_cnt + 1;
    if (done && busy) bad_done <= bad_done + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall ? lfsr[0] : 1'b1;
  end

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic setup_qh(input logic [AW-1:0] a, input logic [31:0] lnk,
                          input logic [31:0] cp, input logic [31:0] st, input logic [31:0] base);
    poke(a, lnk);
    poke(a + 3, cp);
    poke(a + 4, 32'h0000_0c00);
    poke(a + 5, 32'h0000_0c20);
    poke(a + 6, st);
    for (int i = 0; i < 6; i++) poke(a + 12'(7 + i), base + 32'(i));
  endtask

  task automatic wait_done(input string req);
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s watchdog actual no-done expected done", req);
    end
    @(negedge clk);
  endtask

  task automatic launch(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    first_qh = a; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(req);
  endtask

  task automatic check_desc(input string req, input logic [AW-1:0] d,
                            input logic [31:0] st, input logic [31:0] base);
    check32({req, " desc next"}, mem[d], 32'h0000_0c00);
    check32({req, " desc alt"}, mem[d + 1], 32'h0000_0c20);
    check32({req, " desc status"}, mem[d + 2], st);
    for (int i = 0; i < 6; i++) check32({req, " desc buf"}, mem[d + 12'(3 + i)], base + 32'(i));
  endtask

  task automatic t_reset;
    check32("R1 busy", 32'(busy), 0);
    check32("R1 done", 32'(done), 0);
    check32("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_inactive;
    int r0, w0, d0;
    setup_qh(12'h100, 32'h0000_0500, 32'h0000_0800, 32'h0010_0000, 32'h100);
    setup_qh(12'h140, 32'h0000_0600, 32'h0000_0800, 32'h0020_0000, 32'h200);
    setup_qh(12'h180, 32'h0000_0001, 32'h0000_0800, 32'h0030_0000, 32'h300);
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
    launch(12'h100, "R2");
    check32("R3 reads over three heads", 32'(rd_cnt - r0), 33);
    check32("R4 no writes on idle overlays", 32'(wr_cnt - w0), 0);
    check32("R4 status untouched", mem[12'h146], 32'h0020_0000);
    check32("R5 single done pulse", 32'(done_cnt - d0), 1);
    check32("R2 busy low after walk", 32'(busy), 0);
  endtask

  task automatic t_active;
    int r0, w0;
    poke(12'h209, 32'hdead_beef);
    setup_qh(12'h1c0, 32'h0000_0001, 32'h0000_081f, 32'h0028_0c80, 32'ha000);
    r0 = rd_cnt; w0 = wr_cnt;
    launch(12'h1c0, "R6");
    check32("R3 reads one head", 32'(rd_cnt - r0), 11);
    check32("R6 three steps plus R7 nine words", 32'(wr_cnt - w0), 12);
    check32("R6 final status in head", mem[12'h1c6], 32'h0000_0c00);
    check_desc("R7", 12'h200, 32'h0000_0c00, 32'ha000);
    check32("R7 word past descriptor", mem[12'h209], 32'hdead_beef);
    check32("R8 forward pointers unused", 32'(fwd_hits), 0);
  endtask

  task automatic t_zero;
    int w0;
    setup_qh(12'h100, 32'h0000_0001, 32'h0000_0900, 32'h0000_0080, 32'hb000);
    w0 = wr_cnt;
    launch(12'h100, "R6");
    check32("R6 zero count single step", 32'(wr_cnt - w0), 10);
    check32("R6 zero count status", mem[12'h106], 32'h0000_0000);
    check_desc("R7 zero", 12'h240, 32'h0000_0000, 32'hb000);
  endtask

  task automatic t_mixed;
    int r0, w0;
    stall = 1;
    setup_qh(12'h100, 32'h0000_0500, 32'h0000_0800, 32'h0014_0080, 32'hc000);
    setup_qh(12'h140, 32'h0000_0600, 32'h0000_0900, 32'h0040_0000, 32'hd000);
    setup_qh(12'h180, 32'h0000_0001, 32'h0000_0900, 32'h8030_0081, 32'he000);
    r0 = rd_cnt; w0 = wr_cnt;
    launch(12'h100, "R9");
    stall = 0;
    check32("R9 reads under stalls", 32'(rd_cnt - r0), 33);
    check32("R9 writes under stalls", 32'(wr_cnt - w0), 23);
    check32("R6 head A status", mem[12'h106], 32'h0000_0000);
    check32("R4 head B status", mem[12'h146], 32'h0040_0000);
    check32("R6 head C status keeps bits", mem[12'h186], 32'h8000_0001);
    check_desc("R9 A", 12'h200, 32'h0000_0000, 32'hc000);
    check_desc("R9 C", 12'h240, 32'h8000_0001, 32'he000);
    check32("R8 forward pointers unused", 32'(fwd_hits), 0);
  endtask

  task automatic t_busy_start;
    int w0;
    setup_qh(12'h100, 32'h0000_0001, 32'h0000_0800, 32'h0010_0080, 32'hf000);
    setup_qh(12'h1c0, 32'h0000_0001, 32'h0000_0900, 32'h0010_0080, 32'h9000);
    poke(12'h240, 32'h5555_5555);
    w0 = wr_cnt;
    @(negedge clk);
    first_qh = 12'h100; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    first_qh = 12'h1c0; start = 1;
    @(negedge clk);
    start = 0;
    wait_done("R10");
    check32("R10 only first walk wrote", 32'(wr_cnt - w0), 10);
    check32("R10 other descriptor untouched", mem[12'h240], 32'h5555_5555);
    check32("R10 other head still active", mem[12'h1c6], 32'h0010_0080);
    check_desc("R10", 12'h200, 32'h0000_0000, 32'hf000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_inactive();
    t_active();
    t_zero();
    t_mixed();
    t_busy_start();
    check32("R2 done never with busy", 32'(bad_done), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule